// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive engine of a synchronous serial port acting as clock master. It generates the shift clock on `sck_o` and samples the serial data line `sdat_i` into a shift register. Characters are 8 or 9 bits long. A programmable divider sets the clock rate. Each finished character is pushed into a two-entry receive queue. The host sees the oldest entry as a ninth-bit status field and a low-byte data field.

Reception starts in one of two ways. A one-shot request receives exactly one character and then clears itself. A continuous enable receives characters back to back for as long as it is held. The one-shot request affects the port only when the continuous enable is low. A ready flag and a gated interrupt request report that data is waiting.

If a character completes while the queue is full, the character is dropped. An overrun flag is raised and the clock stops. The flag clears only when the continuous enable is dropped or the port is disabled. Disabling the port returns the whole receiver to its reset state.

Top module: `sync_master_rx`

## Requirements
- R1: A character holds 9 bits when `nine_bit_i`=1 and 8 bits otherwise, received least significant bit first. `data_o` shows bits 0..7 of the oldest queued character. `bit9_o` shows its bit 8, which reads 0 for an 8-bit character.
- R2: While no character is in progress, `sck_o` rests at the level of `clk_pol_i`. Each bit begins with an edge away from that level. The data line is sampled on the edge that returns to it.
- R3: Let N = `div_val_i` when `div_wide_i`=1, and N = `div_val_i[7:0]` otherwise. Each half period of `sck_o` lasts N+1 clock cycles when `fast_i`=1 and 4*(N+1) cycles when it is 0.
- R4: A one-cycle pulse on `single_set_i` sets `single_busy_o`. This receives exactly one character. `single_busy_o` clears in the cycle that character completes, and `sck_o` then stays idle.
- R5: While `cont_en_i`=1, characters are received back to back, with one idle cycle between them. A pending one-shot request does not stop this reception.
- R6: The queue holds two characters. A one-cycle pulse on `rd_low_i` pops the oldest one, so `bit9_o` and `data_o` move to the next entry. Both read 0 when the queue is empty.
- R7: `ready_o` is 1 whenever the queue is not empty. `irq_o` equals `ready_o` AND `irq_en_i`.
- R8: When a character completes with the queue full and no pop in that cycle, `overrun_o` goes to 1 and the character is discarded. No new character starts while `overrun_o`=1.
- R9: `overrun_o` stays 1 while `cont_en_i`=1. It reads 0 in the cycle after `cont_en_i` is 0. The queued data is kept.
- R10: When `port_en_i` is 0, the next cycle shows an empty queue, `overrun_o`=0, `single_busy_o`=0 and `sck_o` at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_en_i | input | 1 | Port enable; 0 resets the receiver |
| cont_en_i | input | 1 | Continuous receive enable |
| single_set_i | input | 1 | Pulse requesting one character |
| nine_bit_i | input | 1 | 1 selects 9-bit characters |
| clk_pol_i | input | 1 | Idle level of the shift clock |
| fast_i | input | 1 | High-speed divider mode |
| div_wide_i | input | 1 | Use the full 16-bit divider value |
| div_val_i | input | 16 | Divider value |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_low_i | input | 1 | Read of the low byte; pops the queue |
| sck_o | output | 1 | Shift clock |
| sdat_i | input | 1 | Serial data line |
| single_busy_o | output | 1 | One-shot request pending |
| ready_o | output | 1 | Queue holds at least one character |
| irq_o | output | 1 | Receive interrupt request |
| overrun_o | output | 1 | Overrun error |
| bit9_o | output | 1 | Ninth bit of the oldest character |
| data_o | output | 8 | Low byte of the oldest character |

## Verification
The bench builds the block with its defaults: a 16-bit divider and a two-entry queue. Because the queue is only two deep, overrun is reached after the third unread character. A divider value of zero in fast mode gives one-cycle half periods, which makes cycle-exact checks of back-to-back timing affordable. The bench sweeps all eight combinations of character width, clock polarity and speed mode with one-shot receives. A separate run with the wide divider shows that the high byte of the divider value takes effect.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CHAR_W = 9;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } srx_state_e;

  typedef struct packed {
    logic       hi;
    logic [7:0] lo;
  } srx_char_t;
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fast_i,
  input  logic             wide_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 3;
  localparam int LO_W  = DIV_W / 2;

  logic [CNT_W-1:0] n_w, limit_w, cnt_q;

  always_comb begin
    n_w = '0;
    if (wide_i) n_w[DIV_W-1:0] = div_i;
    else        n_w[LO_W-1:0]  = div_i[LO_W-1:0];
    // half period minus one: N or 4N+3
    limit_w = fast_i ? n_w : ((n_w << 2) + CNT_W'(3));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!run_i || cnt_q >= limit_w) cnt_q <= '0;
    else                                cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = run_i && (cnt_q >= limit_w);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic              single_set_i,
  input  logic              nine_i,
  input  logic              pol_i,
  input  logic              tick_i,
  input  logic              ovr_i,
  input  logic              sdat_i,
  output logic              run_o,
  output logic              sck_o,
  output logic              single_o,
  output logic              done_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int BW = $clog2(CHAR_W);

  srx_state_e        state_q;
  logic              half_q, sck_q, single_q;
  logic [BW-1:0]     bit_cnt_q, last_w;
  logic [CHAR_W-1:0] sreg_q;
  logic              active_w;

  assign active_w = cont_i || single_q;
  assign last_w   = nine_i ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);
  assign done_o   = en_i && active_w && (state_q == ST_SHIFT) && tick_i &&
                    half_q && (bit_cnt_q == last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      bit_cnt_q <= '0;
      sreg_q    <= '0;
      sck_q     <= 1'b0;
      single_q  <= 1'b0;
    end else if (!en_i) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      bit_cnt_q <= '0;
      sck_q     <= pol_i;
      single_q  <= 1'b0;
    end else begin
      if (single_set_i) single_q <= 1'b1;
      else if (done_o)  single_q <= 1'b0;

      if (state_q == ST_IDLE) begin
        sck_q <= pol_i;
        if (active_w && !ovr_i) begin
          state_q   <= ST_SHIFT;
          half_q    <= 1'b0;
          bit_cnt_q <= '0;
          sreg_q    <= '0;
          sck_q     <= ~pol_i;  // leading edge
        end
      end else if (!active_w) begin
        state_q <= ST_IDLE;    // abort
        sck_q   <= pol_i;
      end else if (tick_i) begin
        if (!half_q) begin
          sreg_q[bit_cnt_q] <= sdat_i;  // sample on trailing edge
          half_q            <= 1'b1;
          sck_q             <= pol_i;
        end else if (bit_cnt_q == last_w) begin
          state_q <= ST_IDLE;
        end else begin
          bit_cnt_q <= bit_cnt_q + BW'(1);
          half_q    <= 1'b0;
          sck_q     <= ~pol_i;
        end
      end
    end
  end

  assign run_o    = (state_q == ST_SHIFT);
  assign sck_o    = sck_q;
  assign single_o = single_q;
  assign char_o   = sreg_q;

  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_o && !single_set_i) |=> !single_q); // R4
  AST_OVR_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ovr_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R8
  AST_SCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && active_w && state_q == ST_SHIFT && !tick_i) |=> $stable(sck_q)); // R3
  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> (bit_cnt_q < BW'(CHAR_W))); // R1
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full_o || pop_ok);
  assign dout_o  = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && push_i && full_o && !pop_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import srx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic             cont_en_i,
  input  logic             single_set_i,
  input  logic             nine_bit_i,
  input  logic             clk_pol_i,
  input  logic             fast_i,
  input  logic             div_wide_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             irq_en_i,
  input  logic             rd_low_i,
  output logic             sck_o,
  input  logic             sdat_i,
  output logic             single_busy_o,
  output logic             ready_o,
  output logic             irq_o,
  output logic             overrun_o,
  output logic             bit9_o,
  output logic [7:0]       data_o
);
  logic              run_w, tick_w, done_w, empty_w, full_w, pop_ok_w, ovr_q;
  logic [CHAR_W-1:0] char_w, head_w;
  srx_char_t         head_s;

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni,
    .run_i  (run_w),
    .fast_i (fast_i),
    .wide_i (div_wide_i),
    .div_i  (div_val_i),
    .tick_o (tick_w)
  );

  srx_shift u_shift (
    .clk_i, .rst_ni,
    .en_i         (port_en_i),
    .cont_i       (cont_en_i),
    .single_set_i (single_set_i),
    .nine_i       (nine_bit_i),
    .pol_i        (clk_pol_i),
    .tick_i       (tick_w),
    .ovr_i        (ovr_q),
    .sdat_i       (sdat_i),
    .run_o        (run_w),
    .sck_o        (sck_o),
    .single_o     (single_busy_o),
    .done_o       (done_w),
    .char_o       (char_w)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (!port_en_i),
    .push_i  (done_w && !ovr_q),
    .din_i   (char_w),
    .pop_i   (rd_low_i),
    .dout_o  (head_w),
    .empty_o (empty_w),
    .full_o  (full_w)
  );

  assign pop_ok_w = rd_low_i && !empty_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ovr_q <= 1'b0;
    else if (!port_en_i || !cont_en_i)  ovr_q <= 1'b0;
    else if (done_w && full_w && !pop_ok_w) ovr_q <= 1'b1;
  end

  assign head_s    = head_w;
  assign bit9_o    = head_s.hi;
  assign data_o    = head_s.lo;
  assign ready_o   = !empty_w;
  assign irq_o     = ready_o && irq_en_i;
  assign overrun_o = ovr_q;

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_en_i |=> !overrun_o); // R9
  AST_PORT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (!ready_o && !overrun_o && !single_busy_o)); // R10
endmodule

// File: tb/sync_master_rx_tb.sv
`timescale 1ns/1ps
module sync_master_rx_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        port_en = 1'b1, cont_en = 1'b0, single_set = 1'b0, nine_bit = 1'b0;
  logic        clk_pol = 1'b0, fast = 1'b1, div_wide = 1'b0, irq_en = 1'b0, rd_low = 1'b0;
  logic [15:0] div_val = 16'hFF01;
  logic        sdat = 1'b0;
  logic        sck, single_busy, ready, irq, overrun, bit9;
  logic [7:0]  data;

  int checks = 0, errors = 0;
  logic [8:0] words [8];
  int seq_id = 0;
  int lead_gap = 0, edge_cnt = 0;

  always #2.5 clk = ~clk;

  sync_master_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .cont_en_i(cont_en),
    .single_set_i(single_set), .nine_bit_i(nine_bit), .clk_pol_i(clk_pol),
    .fast_i(fast), .div_wide_i(div_wide), .div_val_i(div_val), .irq_en_i(irq_en),
    .rd_low_i(rd_low), .sck_o(sck), .sdat_i(sdat), .single_busy_o(single_busy),
    .ready_o(ready), .irq_o(irq), .overrun_o(overrun), .bit9_o(bit9), .data_o(data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // slave model: puts the next bit out on each leading edge
  initial begin
    int wi, bi, seen, cyc, last_lead;
    logic prev;
    wi = 0; bi = 0; seen = 0; cyc = 0; last_lead = 0; prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (seen != seq_id) begin seen = seq_id; wi = 0; bi = 0; end
      if (sck !== prev) edge_cnt++;
      if (sck !== prev && sck === ~clk_pol) begin
        if (bi != 0) lead_gap = cyc - last_lead;
        last_lead = cyc;
        sdat = words[wi % 8][bi];
        bi++;
        if (bi >= (nine_bit ? 9 : 8)) begin bi = 0; wi++; end
      end
      prev = sck;
    end
  end

  task automatic pop();
    rd_low = 1'b1; tick(1); rd_low = 1'b0;
  endtask

  task automatic rx_single(input int k, input logic nb, input logic pl, input logic fs, input int hp);
    logic [8:0] w;
    int n, e0;
    w = 9'((k * 73 + 346) % 512);
    nine_bit = nb; clk_pol = pl; fast = fs; irq_en = k[0];
    words[0] = w; seq_id++;
    tick(3);
    chk("R2 idle level", sck, pl);
    single_set = 1'b1; tick(1); single_set = 1'b0;
    chk("R4 busy set", single_busy, 1);
    n = 0;
    while (single_busy && n < 20000) begin tick(1); n++; end
    chk("R7 ready", ready, 1);
    chk("R7 irq", irq, k[0]);
    chk("R1 low byte", data, w[7:0]);
    chk("R1 ninth bit", bit9, nb ? w[8] : 1'b0);
    chk("R3 bit period", lead_gap, 2 * hp);
    e0 = edge_cnt;
    tick(30);
    chk("R4 no further clocks", edge_cnt, e0);
    chk("R2 idle after", sck, pl);
    pop();
    chk("R6 empty after pop", ready, 0);
    chk("R6 zero when empty", data, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL all watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    tick(3); rst_n = 1'b1; tick(1);
    chk("R10 reset sck", sck, 0);
    chk("R10 reset ready", ready, 0);
    chk("R7 reset irq", irq, 0);
    chk("R10 reset overrun", overrun, 0);
    chk("R10 reset busy", single_busy, 0);
    chk("R6 reset data", data, 0);

    // sweep width x polarity x speed, N=1 (high byte ignored)
    for (int k = 0; k < 8; k++)
      rx_single(k, k[2], k[1], k[0], k[0] ? 2 : 8);

    // wide divider: N=258
    div_wide = 1'b1; div_val = 16'h0102;
    rx_single(9, 1'b0, 1'b0, 1'b1, 259);
    div_wide = 1'b0; div_val = 16'hFF00;  // N=0, half period 1 in fast mode

    // continuous reception into overrun
    nine_bit = 1'b1; clk_pol = 1'b0; fast = 1'b1; irq_en = 1'b1;
    for (int i = 0; i < 8; i++) words[i] = 9'((i * 151 + 300) % 512);
    seq_id++; tick(2);
    cont_en = 1'b1;
    n = 0;
    while (!overrun && n < 1000) begin tick(1); n++; end
    chk("R5 back to back timing", n, 57);
    chk("R8 overrun set", overrun, 1);
    chk("R6 head byte", data, words[0][7:0]);
    chk("R6 head ninth", bit9, words[0][8]);
    n = edge_cnt; tick(20);
    chk("R8 clock halted", edge_cnt, n);
    chk("R9 held while enabled", overrun, 1);
    pop();
    chk("R6 next byte", data, words[1][7:0]);
    chk("R6 next ninth", bit9, words[1][8]);
    chk("R9 held after pop", overrun, 1);
    cont_en = 1'b0; tick(1);
    chk("R9 cleared", overrun, 0);
    chk("R9 data kept", data, words[1][7:0]);
    pop();
    chk("R6 drained", ready, 0);

    // continuous precedence over one-shot, 8-bit
    nine_bit = 1'b0;
    for (int i = 0; i < 8; i++) words[i] = 9'((i * 59 + 17) % 512);
    seq_id++; tick(2);
    cont_en = 1'b1; single_set = 1'b1; tick(1); single_set = 1'b0;
    n = 0;
    while (!ready && n < 1000) begin tick(1); n++; end
    tick(20);
    chk("R4 busy cleared", single_busy, 0);
    cont_en = 1'b0; tick(1);
    chk("R5 first char", data, words[0][7:0]);
    pop();
    chk("R5 second char", data, words[1][7:0]);
    chk("R5 second ready", ready, 1);
    pop();
    chk("R6 empty", ready, 0);

    // port disable resets everything
    seq_id++; tick(2);
    cont_en = 1'b1;
    n = 0;
    while (!overrun && n < 1000) begin tick(1); n++; end
    single_set = 1'b1; tick(1); single_set = 1'b0;
    chk("R4 busy before disable", single_busy, 1);
    port_en = 1'b0; tick(1);
    chk("R10 ready cleared", ready, 0);
    chk("R10 overrun cleared", overrun, 0);
    chk("R10 busy cleared", single_busy, 0);
    chk("R10 sck idle", sck, 0);
    chk("R7 irq cleared", irq, 0);
    cont_en = 1'b0; port_en = 1'b1; tick(3);
    chk("R10 stays empty", ready, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule